// File: doc/BRIEF.md
# Product-Term Macrocell Array

This block is a group of sixteen programmable-logic cells that share one input bus. Each cell forms a sum of products. It has five AND terms, and every term can take each bus signal in true form, in complemented form, or not at all. The enabled terms are ORed together. An XOR stage follows the OR, and a flip-flop can hold the result. Three multiplexers set each cell up. The first picks the second XOR input, which is either a fixed polarity bit or the cell's own flip-flop, so the cell can invert or toggle. The second picks what clocks the flip-flop: every global clock edge, or a rising edge of the cell's first product term. The third picks whether the cell output is the registered value or the combinational value.

A cell can lend its last product term to other cells in the group. A lent term leaves the lender's own sum and goes onto a shared line. Any cell can OR into its own sum the lent terms of whichever cells its receive mask selects. All configuration comes in as flat, statically held vectors, and the array computes the sixteen outputs from them.

Top module: `pterm_mc_array`

## Requirements
- R1: Product term k of cell c reads bit `(c*5+k)*NI+i` of the true-literal vector and the same bit of the complement-literal vector for input i. A set true bit requires input i to be 1 and a set complement bit requires it to be 0. If both bits are set, the term is always 0. If no literal is selected, an enabled term is 1.
- R2: A product term whose enable bit `c*5+k` is clear contributes 0. A cell with all terms disabled and nothing borrowed yields 0 before the XOR stage.
- R3: A cell's sum is the OR of all five of its enabled product terms, plus any borrowed terms.
- R4: When the cell's invert bit is set and toggle is clear, the value after the XOR is the complement of the sum.
- R5: In registered mode with the global-clock source, the output takes the XOR result one clock edge after it is presented.
- R6: While rst_n is low at a clock edge, every flip-flop clears to 0. A registered cell then outputs 0.
- R7: With toggle set, the XOR second input is the cell's own flip-flop. A registered cell whose sum is 1 inverts its output on every edge, and holds when the sum is 0.
- R8: With the product-term clock selected, the flip-flop loads only at an edge where term 0 is 1 and was 0 at the previous edge. At all other edges it holds.
- R9: When a cell's lend bit is set, its term 4 is removed from its own sum and driven onto that cell's shared line.
- R10: Cell r ORs into its sum the shared line of every cell s with mask bit `r*16+s` set. A term that is not lent places 0 on the shared line.
- R11: In combinational mode, the output follows the input bus within the same cycle and does not wait for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Synchronous active-low reset of all cell flip-flops |
| in_i | input | NUM_IN | Shared input bus |
| cfg_true_i | input | NUM_CELLS*NUM_PT*NUM_IN | True-literal selects |
| cfg_comp_i | input | NUM_CELLS*NUM_PT*NUM_IN | Complement-literal selects |
| cfg_pt_en_i | input | NUM_CELLS*NUM_PT | Product-term enables |
| cfg_lend_i | input | NUM_CELLS | Lend term 4 onto the shared line |
| cfg_share_i | input | NUM_CELLS*NUM_CELLS | Receive masks, bit r*NUM_CELLS+s |
| cfg_invert_i | input | NUM_CELLS | XOR polarity bit |
| cfg_toggle_i | input | NUM_CELLS | XOR second input from the own flip-flop |
| cfg_ptclk_i | input | NUM_CELLS | Flip-flop triggered by term 0 rising |
| cfg_reg_i | input | NUM_CELLS | Output from the flip-flop (1) or combinational (0) |
| out_o | output | NUM_CELLS | Cell outputs |

## Verification
The hardest situation to reach is the product-term clock. A cell must see term 0 rise between two global edges while its data term changes independently. It must also hold while term 0 stays high or falls. The bench drives a directed sequence on two separate input bits to reach it. Lending is driven the same way: one cell lends a term to another, and a neighbour keeps an identical term without lending it, so that a wrongly shared line shows up at the ports. Random configurations with sparse literals then keep terms switching, and the reference model is compared with the outputs every cycle.

// File: rtl/pterm_mc_pkg.sv
// Package: shared types of the product-term macrocell array.
// Assumes: nothing beyond IEEE 1800-2017.
package pterm_mc_pkg;

    // Static per-cell multiplexer and lending settings.
    typedef struct packed {
        logic invert;      // XOR second input when not toggling
        logic toggle;      // XOR second input taken from own flip-flop
        logic ptclk;       // flip-flop triggered by rising term 0
        logic registered;  // output from flip-flop
        logic lend;        // term LEND_IDX goes to the shared line
    } mc_mode_t;

endpackage

// File: rtl/pterm_and_plane.sv
// Module: pterm_and_plane
// Computes the NUM_PT product terms of one cell from the input bus.
// Assumes: the literal-select vectors are indexed term*NUM_IN+input.
// If a term has both literals of one input set, it evaluates to 0.
module pterm_and_plane #(
    parameter int NUM_IN = 8,
    parameter int NUM_PT = 5
) (
    input  logic [NUM_IN-1:0]        in_i,
    input  logic [NUM_PT*NUM_IN-1:0] use_true_i,
    input  logic [NUM_PT*NUM_IN-1:0] use_comp_i,
    input  logic [NUM_PT-1:0]        term_en_i,
    output logic [NUM_PT-1:0]        term_o
);

    for (genvar k = 0; k < NUM_PT; k++) begin : g_term
        logic [NUM_IN-1:0] lit_ok;

        // Each input passes unless a selected literal disagrees with it.
        always_comb begin
            lit_ok = (~use_true_i[k*NUM_IN +: NUM_IN] | in_i)
                   & (~use_comp_i[k*NUM_IN +: NUM_IN] | ~in_i);
        end

        // Disabled terms are forced to 0.
        always_comb begin
            term_o[k] = term_en_i[k] & (&lit_ok);
        end
    end

endmodule

// File: rtl/pterm_share_net.sv
// Module: pterm_share_net
// Routes lent product terms to the cells that receive them.
// Assumes: the mask is indexed receiver*NUM_CELLS+source. A cell may
// receive its own lent term.
module pterm_share_net #(
    parameter int NUM_CELLS = 16
) (
    input  logic [NUM_CELLS-1:0]           lend_i,
    input  logic [NUM_CELLS*NUM_CELLS-1:0] mask_i,
    output logic [NUM_CELLS-1:0]           borrow_o
);

    for (genvar r = 0; r < NUM_CELLS; r++) begin : g_recv
        // OR of the selected shared lines.
        always_comb begin
            borrow_o[r] = |(mask_i[r*NUM_CELLS +: NUM_CELLS] & lend_i);
        end
    end

endmodule

// File: rtl/pterm_cell.sv
// Module: pterm_cell
// One macrocell: OR of its terms, XOR stage, flip-flop and three
// multiplexers (XOR source, trigger source, output source).
// Assumes: NUM_PT >= 2. Term 0 doubles as the clock term and the last
// term is the lendable one. The flip-flop runs on the global clock, and
// in product-term-clock mode it loads only on a sampled rising edge of term 0.
module pterm_cell
    import pterm_mc_pkg::*;
#(
    parameter int NUM_PT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PT-1:0] term_i,
    input  logic              borrow_i,
    input  mc_mode_t          mode_i,
    output logic              lend_o,
    output logic              d_o,
    output logic              q_o,
    output logic              out_o
);

    localparam int LEND_IDX = NUM_PT - 1;
    localparam int CLK_IDX  = 0;

    logic own_sum;
    logic sum;
    logic xor_b;
    logic trig_prev;
    logic capture;

    // Sum of own terms; a lent term is left out.
    always_comb begin
        own_sum = (|term_i[LEND_IDX-1:0]) | (term_i[LEND_IDX] & ~mode_i.lend);
    end

    // Lent term onto the shared line.
    always_comb begin
        lend_o = term_i[LEND_IDX] & mode_i.lend;
    end

    // Full sum including borrowed terms.
    always_comb begin
        sum = own_sum | borrow_i;
    end

    // XOR source multiplexer: polarity bit or own flip-flop.
    always_comb begin
        xor_b = mode_i.toggle ? q_o : mode_i.invert;
    end

    // XOR stage.
    always_comb begin
        d_o = sum ^ xor_b;
    end

    // Trigger source multiplexer: every edge or a rising clock term.
    always_comb begin
        capture = mode_i.ptclk ? (term_i[CLK_IDX] & ~trig_prev) : 1'b1;
    end

    // Flip-flop and clock-term history with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o       <= 1'b0;
            trig_prev <= 1'b0;
        end else begin
            trig_prev <= term_i[CLK_IDX];
            if (capture) begin
                q_o <= d_o;
            end
        end
    end

    // Output source multiplexer.
    always_comb begin
        out_o = mode_i.registered ? q_o : d_o;
    end

endmodule

// File: rtl/pterm_mc_array.sv
// Module: pterm_mc_array (top)
// A group of NUM_CELLS macrocells on one shared input bus, with
// product-term lending inside the group.
// Assumes: configuration inputs are held static, or change only between
// evaluations. All flip-flops use clk and a synchronous active-low reset.
module pterm_mc_array
    import pterm_mc_pkg::*;
#(
    parameter int NUM_CELLS = 16,
    parameter int NUM_PT    = 5,
    parameter int NUM_IN    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_IN-1:0]                 in_i,
    input  logic [NUM_CELLS*NUM_PT*NUM_IN-1:0] cfg_true_i,
    input  logic [NUM_CELLS*NUM_PT*NUM_IN-1:0] cfg_comp_i,
    input  logic [NUM_CELLS*NUM_PT-1:0]       cfg_pt_en_i,
    input  logic [NUM_CELLS-1:0]              cfg_lend_i,
    input  logic [NUM_CELLS*NUM_CELLS-1:0]    cfg_share_i,
    input  logic [NUM_CELLS-1:0]              cfg_invert_i,
    input  logic [NUM_CELLS-1:0]              cfg_toggle_i,
    input  logic [NUM_CELLS-1:0]              cfg_ptclk_i,
    input  logic [NUM_CELLS-1:0]              cfg_reg_i,
    output logic [NUM_CELLS-1:0]              out_o
);

    localparam int PLANE_W = NUM_PT * NUM_IN;

    logic [NUM_CELLS-1:0] lend_w;
    logic [NUM_CELLS-1:0] borrow_w;
    logic [NUM_CELLS-1:0] pt0_w;
    logic [NUM_CELLS-1:0] d_w;
    logic [NUM_CELLS-1:0] q_w;

    pterm_share_net #(
        .NUM_CELLS(NUM_CELLS)
    ) share_i (
        .lend_i  (lend_w),
        .mask_i  (cfg_share_i),
        .borrow_o(borrow_w)
    );

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        logic [NUM_PT-1:0] terms;
        mc_mode_t          mode;

        // Gather this cell's mode bits.
        always_comb begin
            mode.invert     = cfg_invert_i[c];
            mode.toggle     = cfg_toggle_i[c];
            mode.ptclk      = cfg_ptclk_i[c];
            mode.registered = cfg_reg_i[c];
            mode.lend       = cfg_lend_i[c];
        end

        pterm_and_plane #(
            .NUM_IN(NUM_IN),
            .NUM_PT(NUM_PT)
        ) plane_i (
            .in_i      (in_i),
            .use_true_i(cfg_true_i[c*PLANE_W +: PLANE_W]),
            .use_comp_i(cfg_comp_i[c*PLANE_W +: PLANE_W]),
            .term_en_i (cfg_pt_en_i[c*NUM_PT +: NUM_PT]),
            .term_o    (terms)
        );

        pterm_cell #(
            .NUM_PT(NUM_PT)
        ) cell_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .term_i  (terms),
            .borrow_i(borrow_w[c]),
            .mode_i  (mode),
            .lend_o  (lend_w[c]),
            .d_o     (d_w[c]),
            .q_o     (q_w[c]),
            .out_o   (out_o[c])
        );

        // Clock term exposed for checking.
        always_comb begin
            pt0_w[c] = terms[0];
        end
    end

endmodule

// File: rtl/pterm_mc_array_chk.sv
// Module: pterm_mc_array_chk
// Property checker for pterm_mc_array, attached by bind.
// Assumes: configuration stays static across the checked cycles.
module pterm_mc_array_chk #(
    parameter int NUM_CELLS = 16,
    parameter int NUM_PT    = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_CELLS*NUM_PT-1:0] cfg_pt_en_i,
    input logic [NUM_CELLS-1:0]        cfg_lend_i,
    input logic [NUM_CELLS-1:0]        cfg_ptclk_i,
    input logic [NUM_CELLS-1:0]        cfg_reg_i,
    input logic [NUM_CELLS-1:0]        out_o,
    input logic [NUM_CELLS-1:0]        lend_w,
    input logic [NUM_CELLS-1:0]        pt0_w,
    input logic [NUM_CELLS-1:0]        d_w,
    input logic [NUM_CELLS-1:0]        q_w
);

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> ((out_o & cfg_reg_i) == '0));

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_chk
        // R5
        global_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_ptclk_i[c] |=> (q_w[c] == $past(d_w[c])));

        // R8
        ptclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_ptclk_i[c] && !pt0_w[c]) |=> $stable(q_w[c]));

        // R9
        lend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_lend_i[c] |-> !lend_w[c]);

        // R2
        disabled_lend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_pt_en_i[c*NUM_PT +: NUM_PT] == '0) |-> !lend_w[c]);
    end

endmodule

bind pterm_mc_array pterm_mc_array_chk #(
    .NUM_CELLS(NUM_CELLS),
    .NUM_PT   (NUM_PT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_pt_en_i(cfg_pt_en_i),
    .cfg_lend_i (cfg_lend_i),
    .cfg_ptclk_i(cfg_ptclk_i),
    .cfg_reg_i  (cfg_reg_i),
    .out_o      (out_o),
    .lend_w     (lend_w),
    .pt0_w      (pt0_w),
    .d_w        (d_w),
    .q_w        (q_w)
);

// File: tb/pterm_mc_array_tb_top.sv
`timescale 1ns/1ps
module pterm_mc_array_tb_top;

    localparam int NC = 16;
    localparam int NP = 5;
    localparam int NI = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NI-1:0]       in_v = '0;
    logic [NC*NP*NI-1:0] c_true = '0;
    logic [NC*NP*NI-1:0] c_comp = '0;
    logic [NC*NP-1:0]    c_en = '0;
    logic [NC-1:0]       c_lend = '0;
    logic [NC*NC-1:0]    c_share = '0;
    logic [NC-1:0]       c_inv = '0;
    logic [NC-1:0]       c_tog = '0;
    logic [NC-1:0]       c_ptclk = '0;
    logic [NC-1:0]       c_reg = '0;
    logic [NC-1:0]       out_w;

    logic [NC-1:0] m_q = '0;
    logic [NC-1:0] m_prev = '0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pterm_mc_array #(.NUM_CELLS(NC), .NUM_PT(NP), .NUM_IN(NI)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_i(in_v),
        .cfg_true_i(c_true), .cfg_comp_i(c_comp), .cfg_pt_en_i(c_en),
        .cfg_lend_i(c_lend), .cfg_share_i(c_share), .cfg_invert_i(c_inv),
        .cfg_toggle_i(c_tog), .cfg_ptclk_i(c_ptclk), .cfg_reg_i(c_reg),
        .out_o(out_w)
    );

    // Behavioural value of one product term.
    function automatic logic term_val(int c, int k);
        logic v = c_en[c*NP+k];
        for (int i = 0; i < NI; i++) begin
            if (c_true[(c*NP+k)*NI+i] && !in_v[i]) v = 1'b0;
            if (c_comp[(c*NP+k)*NI+i] && in_v[i]) v = 1'b0;
        end
        return v;
    endfunction

    // Model outputs, XOR results and clock terms for the current inputs.
    task automatic model_eval(output logic [NC-1:0] o, output logic [NC-1:0] d,
                              output logic [NC-1:0] t0);
        logic [NC-1:0] lent;
        for (int s = 0; s < NC; s++) lent[s] = term_val(s, NP-1) && c_lend[s];
        for (int c = 0; c < NC; c++) begin
            logic sum = 1'b0;
            for (int k = 0; k < NP-1; k++) if (term_val(c, k)) sum = 1'b1;
            if (term_val(c, NP-1) && !c_lend[c]) sum = 1'b1;
            for (int s = 0; s < NC; s++) if (c_share[c*NC+s] && lent[s]) sum = 1'b1;
            d[c]  = sum ^ (c_tog[c] ? m_q[c] : c_inv[c]);
            t0[c] = term_val(c, 0);
            o[c]  = c_reg[c] ? m_q[c] : d[c];
        end
    endtask

    // One cycle: compare after the inputs settle, then advance the model at the edge.
    task automatic step(input string tag);
        logic [NC-1:0] eo, ed, et;
        #1;
        model_eval(eo, ed, et);
        checks++;
        if (out_w !== eo) begin
            fails++;
            $display("FAIL %s: out=%h expected=%h", tag, out_w, eo);
        end
        @(posedge clk);
        for (int c = 0; c < NC; c++) begin
            if (!rst_n) begin
                m_q[c] = 1'b0;
                m_prev[c] = 1'b0;
            end else begin
                if (!c_ptclk[c] || (et[c] && !m_prev[c])) m_q[c] = ed[c];
                m_prev[c] = et[c];
            end
        end
        @(negedge clk);
    endtask

    task automatic clear_cfg();
        c_true = '0; c_comp = '0; c_en = '0; c_lend = '0; c_share = '0;
        c_inv = '0; c_tog = '0; c_ptclk = '0; c_reg = '0;
    endtask

    task automatic lit(int c, int k, int i, bit comp);
        c_en[c*NP+k] = 1'b1;
        if (comp) c_comp[(c*NP+k)*NI+i] = 1'b1;
        else      c_true[(c*NP+k)*NI+i] = 1'b1;
    endtask

    task automatic rand_cfg();
        for (int b = 0; b < NC*NP*NI; b++) begin
            c_true[b] = ($urandom_range(0, 11) == 0);
            c_comp[b] = ($urandom_range(0, 11) == 0);
        end
        for (int b = 0; b < NC*NP; b++) c_en[b] = ($urandom_range(0, 2) != 0);
        for (int b = 0; b < NC*NC; b++) c_share[b] = ($urandom_range(0, 7) == 0);
        c_lend = NC'($urandom); c_inv = NC'($urandom); c_tog = NC'($urandom);
        c_ptclk = NC'($urandom); c_reg = NC'($urandom);
    endtask

    initial begin
        #(8*200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: out=%h expected=finish", out_w);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R6: reset holds registered cells at 0 whatever the data terms say.
        c_reg = '1;
        for (int c = 0; c < NC; c++) c_en[c*NP+1] = 1'b1;
        c_inv = 16'hA5A5;
        for (int n = 0; n < 3; n++) begin in_v = NI'(n * 37); step("R6 reset"); end
        rst_n = 1'b1;
        step("R6 release");
        step("R5 first load");

        // R2: every term disabled, combinational, no polarity.
        clear_cfg();
        for (int n = 0; n < 4; n++) begin in_v = NI'(n * 85); step("R2 disabled terms"); end

        // R1: literal polarity, contradictory literals, empty enabled term.
        clear_cfg();
        lit(0, 0, 0, 0); lit(1, 0, 0, 1);
        lit(2, 0, 0, 0); lit(2, 0, 0, 1);
        c_en[3*NP+0] = 1'b1;
        lit(4, 2, 3, 0); lit(4, 2, 6, 1);
        foreach (in_v[i]) in_v[i] = 1'b0;
        for (int n = 0; n < 6; n++) begin in_v = NI'(n * 73 + 1); step("R1 literals"); end

        // R3: five single-literal terms per cell, OR of all of them.
        clear_cfg();
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < NP; k++) lit(c, k, (c + k) % NI, (k == 2));
        for (int n = 0; n < 8; n++) begin in_v = NI'(1 << n); step("R3 sum of terms"); end
        in_v = 8'h04; step("R3 sum of terms");

        // R4: inversion.
        c_inv = 16'hFF00;
        for (int n = 0; n < 4; n++) begin in_v = NI'(n * 29); step("R4 polarity"); end

        // R11: combinational outputs change with inputs mid-cycle.
        c_inv = '0;
        in_v = 8'h01; #2; in_v = 8'h80; step("R11 combinational");

        // R5: registered, global clock.
        c_reg = '1;
        for (int n = 0; n < 5; n++) begin in_v = NI'(n * 51 + 3); step("R5 registered"); end

        // R7: toggle with constant-1 sum, then hold with sum 0.
        clear_cfg();
        c_en[11*NP+0] = 1'b1; c_tog[11] = 1'b1; c_reg[11] = 1'b1;
        lit(12, 0, 2, 0); c_tog[12] = 1'b1; c_reg[12] = 1'b1;
        for (int n = 0; n < 6; n++) begin in_v = (n < 3) ? 8'h04 : 8'h00; step("R7 toggle"); end

        // R8: clock term on input 0, data term on input 1.
        clear_cfg();
        lit(10, 0, 0, 0); lit(10, 1, 1, 0);
        c_ptclk[10] = 1'b1; c_reg[10] = 1'b1; c_inv[10] = 1'b1;
        begin
            logic [1:0] seq [12] = '{2'b00, 2'b10, 2'b01, 2'b11, 2'b10, 2'b01,
                                     2'b00, 2'b11, 2'b01, 2'b00, 2'b10, 2'b11};
            for (int n = 0; n < 12; n++) begin in_v = {6'b0, seq[n]}; step("R8 term clock"); end
        end

        // R9 / R10: cell 5 lends term 4, cell 6 borrows it; cell 8 keeps its own.
        clear_cfg();
        lit(5, 4, 3, 0); c_lend[5] = 1'b1;
        c_share[6*NC+5] = 1'b1;
        lit(8, 4, 3, 0);
        c_share[7*NC+8] = 1'b1;
        lit(9, 4, 5, 1); c_lend[9] = 1'b1; c_share[9*NC+9] = 1'b1;
        for (int n = 0; n < 6; n++) begin in_v = NI'(n * 9); step("R9 R10 lending"); end

        // R3 with random configurations, plus a reset pulse per run.
        for (int r = 0; r < 14; r++) begin
            rand_cfg();
            for (int n = 0; n < 14; n++) begin
                in_v = NI'($urandom);
                rst_n = (n != 6);
                step("R3 random");
            end
            rst_n = 1'b1;
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule